// File: doc/BRIEF.md
# Split-Read Request Throttle

This block decides, cycle by cycle, whether the transmit-side DMA read requester or the receive-side DMA read requester may launch a new split read on the host bus. It keeps a count of split reads that have been issued but not yet completed. It grants at most one new read per cycle, and only while that count is below a limit chosen by a 3-bit configuration code.

Transmit reads also have a lower, separately programmed ceiling, the shared-split level. When the outstanding count reaches that level, transmit reads stop and the remaining headroom is held for receive traffic. A shared-split level of zero switches this ceiling off, and both sides then compete for the full limit.

Every grant carries a byte size. This is the requested length, clamped to the largest read the bus is configured to allow. A requester whose read was clamped issues the remainder later as a new request. Grants are combinational: they depend on the present requests and the present count. The count changes at the next clock edge.

Top module: `srd_throttle`

## Requirements
- R1: The global limit code `max_out_code` selects 1, 2, 3, 4, 8, 12, 16 or 32 outstanding reads for codes 0 to 7. A receive request is granted only while the outstanding count is below that limit.
- R2: When `shared_lim` is nonzero and the outstanding count is equal to or above it, no transmit request is granted. Receive requests remain subject only to R1.
- R3: When `shared_lim` is zero, transmit requests are granted up to the global limit, the same as receive requests.
- R4: At most one of `tx_gnt` and `rx_gnt` is high in any cycle, and a grant is only given to a side whose request is high.
- R5: When both sides request and both are eligible, the grant goes to the side that did not receive the most recent grant.
- R6: At each clock edge the count rises by one after a grant and falls by one after a `cpl_done` strobe. A grant and a strobe in the same cycle leave the count unchanged.
- R7: A `cpl_done` strobe while the count is zero is ignored. The count stays at zero and does not wrap.
- R8: `gnt_bytes` equals the granted side's requested length, capped at 512, 1024, 2048 or 4096 bytes for `rd_size_code` 0, 1, 2 or 3. It is zero in cycles without a grant.
- R9: After reset the count is zero, and the first contested grant goes to the transmit side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_req | input | 1 | Transmit side wants to issue a read |
| tx_len | input | 13 | Transmit requested length in bytes |
| rx_req | input | 1 | Receive side wants to issue a read |
| rx_len | input | 13 | Receive requested length in bytes |
| cpl_done | input | 1 | One outstanding split read has completed |
| max_out_code | input | 3 | Global outstanding-limit code |
| shared_lim | input | 5 | Transmit ceiling on outstanding reads, 0 = off |
| rd_size_code | input | 2 | Maximum read size code |
| tx_gnt | output | 1 | Transmit request granted this cycle |
| rx_gnt | output | 1 | Receive request granted this cycle |
| gnt_bytes | output | 13 | Byte size of the granted read |

## Verification
The following properties are checked on every cycle:
- Only one grant is given per cycle, and only to a requesting side.
- Receive grants never exceed the global limit.
- Transmit grants are blocked at the shared-split level.
- The count moves by exactly one or holds, including at zero.
- The granted size never exceeds the cap.

Some behaviour can only be shown by the bench's scenarios, which compare against an independent model:
- The round-robin order when both sides contend.
- The exact decoded limit for each code.
- That the shared-split level of zero really opens transmit up to the global limit.
- The exact clamped byte sizes at lengths just below, at and above each cap.

// File: rtl/srt_pkg.sv
package srt_pkg;

   // Identifies which requester a grant belongs to.
   typedef enum logic {
      SIDE_TX = 1'b0,
      SIDE_RX = 1'b1
   } side_e;

   // Global outstanding-read limit selected by the 3-bit code.
   function automatic int unsigned lim_from_code(input logic [2:0] code);
      case (code)
         3'd0:    return 1;
         3'd1:    return 2;
         3'd2:    return 3;
         3'd3:    return 4;
         3'd4:    return 8;
         3'd5:    return 12;
         3'd6:    return 16;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/srt_cfg_decode.sv
module srt_cfg_decode #(
   parameter int CW         = 6,
   parameter int LEN_W      = 13,
   parameter int BASE_BYTES = 512
) (
   input  logic [2:0]       max_code,
   input  logic [1:0]       size_code,
   output logic [CW-1:0]    lim,
   output logic [LEN_W-1:0] cap
);
   import srt_pkg::*;

   localparam logic [LEN_W-1:0] BASE_L = LEN_W'(BASE_BYTES);

   always_comb begin
      lim = CW'(lim_from_code(max_code));
      cap = BASE_L << size_code;
   end
endmodule

// File: rtl/srt_size_clamp.sv
module srt_size_clamp #(
   parameter int LEN_W = 13
) (
   input  logic [LEN_W-1:0] want,
   input  logic [LEN_W-1:0] cap,
   output logic [LEN_W-1:0] sized
);
   always_comb sized = (want > cap) ? cap : want;
endmodule

// File: rtl/srt_rr_arb.sv
module srt_rr_arb #(
   parameter bit FIRST_RX = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_ok,
   input  logic rx_ok,
   output logic tx_win,
   output logic rx_win
);
   logic favor_rx;

   always_comb begin
      tx_win = tx_ok && (!rx_ok || !favor_rx);
      rx_win = rx_ok && (!tx_ok || favor_rx);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      favor_rx <= FIRST_RX;
      else if (tx_win) favor_rx <= 1'b1;
      else if (rx_win) favor_rx <= 1'b0;
   end
endmodule

// File: rtl/srt_out_counter.sv
module srt_out_counter #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          up,
   input  logic          down,
   output logic [CW-1:0] level
);
   logic down_eff;

   always_comb down_eff = down && (level != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= '0;
      end else begin
         case ({up, down_eff})
            2'b10:   level <= level + CW'(1);
            2'b01:   level <= level - CW'(1);
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/srd_throttle.sv
module srd_throttle #(
   parameter int LEN_W      = 13,
   parameter int CW         = 6,
   parameter int SHR_W      = 5,
   parameter int BASE_BYTES = 512,
   parameter bit FIRST_RX   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_req,
   input  logic [LEN_W-1:0] tx_len,
   input  logic             rx_req,
   input  logic [LEN_W-1:0] rx_len,
   input  logic             cpl_done,
   input  logic [2:0]       max_out_code,
   input  logic [SHR_W-1:0] shared_lim,
   input  logic [1:0]       rd_size_code,
   output logic             tx_gnt,
   output logic             rx_gnt,
   output logic [LEN_W-1:0] gnt_bytes
);
   import srt_pkg::*;

   localparam int NSIDE = 2;

   if ((1 << CW) <= 32) begin : g_bad_cw
      $error("srd_throttle: CW too narrow to hold 32 outstanding reads");
   end
   if (CW < SHR_W) begin : g_bad_shr
      $error("srd_throttle: SHR_W must not exceed CW");
   end
   if (BASE_BYTES * 8 >= (1 << LEN_W)) begin : g_bad_len
      $error("srd_throttle: LEN_W too narrow for the largest read size");
   end

   logic [CW-1:0]    outstanding;
   logic [CW-1:0]    glob_max;
   logic [LEN_W-1:0] cap_bytes;
   logic [CW-1:0]    shr_ext;
   logic             below_max, below_shared;
   logic             tx_ok, rx_ok;
   logic [LEN_W-1:0] want_len [NSIDE];
   logic [LEN_W-1:0] sized_len[NSIDE];

   srt_cfg_decode #(.CW(CW), .LEN_W(LEN_W), .BASE_BYTES(BASE_BYTES)) u_dec (
      .max_code  (max_out_code),
      .size_code (rd_size_code),
      .lim       (glob_max),
      .cap       (cap_bytes)
   );

   always_comb begin
      shr_ext      = CW'(shared_lim);
      below_max    = outstanding < glob_max;
      below_shared = (shr_ext == '0) || (outstanding < shr_ext);
      tx_ok        = tx_req && below_max && below_shared;
      rx_ok        = rx_req && below_max;
      want_len[SIDE_TX] = tx_len;
      want_len[SIDE_RX] = rx_len;
   end

   for (genvar s = 0; s < NSIDE; s++) begin : g_clamp
      srt_size_clamp #(.LEN_W(LEN_W)) u_clamp (
         .want  (want_len[s]),
         .cap   (cap_bytes),
         .sized (sized_len[s])
      );
   end

   srt_rr_arb #(.FIRST_RX(FIRST_RX)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .tx_ok  (tx_ok),
      .rx_ok  (rx_ok),
      .tx_win (tx_gnt),
      .rx_win (rx_gnt)
   );

   srt_out_counter #(.CW(CW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .up    (tx_gnt || rx_gnt),
      .down  (cpl_done),
      .level (outstanding)
   );

   always_comb begin
      if (tx_gnt)      gnt_bytes = sized_len[SIDE_TX];
      else if (rx_gnt) gnt_bytes = sized_len[SIDE_RX];
      else             gnt_bytes = '0;
   end
endmodule

// File: rtl/srd_throttle_chk.sv
module srd_throttle_chk #(
   parameter int LEN_W = 13,
   parameter int CW    = 6,
   parameter int SHR_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_req,
   input logic             rx_req,
   input logic             cpl_done,
   input logic             tx_gnt,
   input logic             rx_gnt,
   input logic [SHR_W-1:0] shared_lim,
   input logic [CW-1:0]    cnt,
   input logic [CW-1:0]    gmax,
   input logic [LEN_W-1:0] gnt_bytes,
   input logic [LEN_W-1:0] cap
);
   logic any_gnt;
   assign any_gnt = tx_gnt || rx_gnt;

   a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_gnt && rx_gnt));
   a_r4_tx_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      tx_gnt |-> tx_req);
   a_r4_rx_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      rx_gnt |-> rx_req);
   a_r1_rx_limit: assert property (@(posedge clk) disable iff (!rst_n)
      rx_gnt |-> (cnt < gmax));
   a_r2_tx_shared: assert property (@(posedge clk) disable iff (!rst_n)
      ((shared_lim != '0) && (cnt >= CW'(shared_lim))) |-> !tx_gnt);
   a_r6_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      (any_gnt && !cpl_done) |=> (cnt == $past(cnt) + CW'(1)));
   a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_gnt && cpl_done && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));
   a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (any_gnt && cpl_done && cnt != '0) |=> $stable(cnt));
   a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_gnt && cpl_done && cnt == '0) |=> (cnt == '0));
   a_r8_size_cap: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_bytes <= cap);
   a_r8_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !any_gnt |-> (gnt_bytes == '0));
endmodule

bind srd_throttle srd_throttle_chk #(.LEN_W(LEN_W), .CW(CW), .SHR_W(SHR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_req     (tx_req),
   .rx_req     (rx_req),
   .cpl_done   (cpl_done),
   .tx_gnt     (tx_gnt),
   .rx_gnt     (rx_gnt),
   .shared_lim (shared_lim),
   .cnt        (outstanding),
   .gmax       (glob_max),
   .gnt_bytes  (gnt_bytes),
   .cap        (cap_bytes)
);

// File: tb/srd_throttle_bench.sv
module srd_throttle_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        tx_req, rx_req, cpl_done;
   logic [12:0] tx_len, rx_len;
   logic [2:0]  max_out_code;
   logic [4:0]  shared_lim;
   logic [1:0]  rd_size_code;
   logic        tx_gnt, rx_gnt;
   logic [12:0] gnt_bytes;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   int m_cnt = 0;
   bit m_favor_rx = 0;

   always #2 clk = ~clk;

   srd_throttle u_srd_throttle (
      .clk(clk), .rst_n(rst_n),
      .tx_req(tx_req), .tx_len(tx_len),
      .rx_req(rx_req), .rx_len(rx_len),
      .cpl_done(cpl_done),
      .max_out_code(max_out_code), .shared_lim(shared_lim),
      .rd_size_code(rd_size_code),
      .tx_gnt(tx_gnt), .rx_gnt(rx_gnt), .gnt_bytes(gnt_bytes)
   );

   function automatic int f_lim(input int code);
      case (code)
         0: return 1;
         1: return 2;
         2: return 3;
         3: return 4;
         4: return 8;
         5: return 12;
         6: return 16;
         default: return 32;
      endcase
   endfunction

   function automatic int f_cap(input int code);
      return 512 << code;
   endfunction

   function automatic int f_clamp(input int len, input int code);
      return (len > f_cap(code)) ? f_cap(code) : len;
   endfunction

   // Drives one cycle from just after a falling edge, checks the grants and
   // size against the model, then advances the model over the rising edge.
   task automatic cyc(input bit t, input int tl, input bit r, input int rl,
                      input bit c, input string tag);
      bit el_t, el_r, e_t, e_r;
      int e_b, lim;
      tx_req = t; tx_len = 13'(tl); rx_req = r; rx_len = 13'(rl); cpl_done = c;
      #1;
      lim  = f_lim(int'(max_out_code));
      el_r = r && (m_cnt < lim);
      el_t = t && (m_cnt < lim) && (shared_lim == 0 || m_cnt < int'(shared_lim));
      e_t  = el_t && (!el_r || !m_favor_rx);
      e_r  = el_r && (!el_t || m_favor_rx);
      e_b  = e_t ? f_clamp(tl, int'(rd_size_code)) :
             e_r ? f_clamp(rl, int'(rd_size_code)) : 0;
      checks++;
      if (tx_gnt !== e_t || rx_gnt !== e_r || int'(gnt_bytes) != e_b) begin
         failures++;
         $display("FAIL %s: actual tx=%0b rx=%0b bytes=%0d expected tx=%0b rx=%0b bytes=%0d (cnt=%0d)",
                  tag, tx_gnt, rx_gnt, gnt_bytes, e_t, e_r, e_b, m_cnt);
      end
      @(posedge clk);
      if ((e_t || e_r) && !(c && m_cnt > 0)) m_cnt++;
      else if (!(e_t || e_r) && c && m_cnt > 0) m_cnt--;
      if (e_t) m_favor_rx = 1;
      else if (e_r) m_favor_rx = 0;
      @(negedge clk);
   endtask

   task automatic drain();
      while (m_cnt > 0) cyc(0, 0, 0, 0, 1, "R6 drain");
   endtask

   initial begin
      rst_n = 0; tx_req = 0; rx_req = 0; cpl_done = 0;
      tx_len = 0; rx_len = 0;
      max_out_code = 0; shared_lim = 0; rd_size_code = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R9: count at zero and transmit wins the first contest
      cyc(1, 100, 1, 200, 0, "R9 reset");
      // R1: limit 1 reached, both blocked
      cyc(1, 100, 1, 200, 0, "R1 limit code0");
      cyc(0, 0, 0, 0, 1, "R6 completion");
      // R5: receive wins the next contest
      cyc(1, 100, 1, 200, 0, "R5 alternate");
      cyc(0, 0, 0, 0, 1, "R6 completion");
      // R7: strobe at zero ignored, then a grant still possible at limit 1
      cyc(0, 0, 0, 0, 1, "R7 strobe at zero");
      cyc(0, 0, 1, 64, 0, "R7 no wrap");
      drain();

      // R2: shared level 3 blocks transmit, receive continues
      max_out_code = 7; shared_lim = 3;
      for (int i = 0; i < 5; i++) cyc(1, 256, 0, 0, 0, "R2 tx shared");
      cyc(1, 256, 1, 256, 0, "R2 rx passes");
      drain();

      // R3: shared level off, transmit reaches the global limit of 3
      max_out_code = 2; shared_lim = 0;
      for (int i = 0; i < 5; i++) cyc(1, 300, 0, 0, 0, "R3 tx to global");
      drain();

      // R6: grant and completion together hold the count
      cyc(0, 0, 1, 10, 0, "R6 fill");
      cyc(0, 0, 1, 10, 0, "R6 fill");
      cyc(0, 0, 1, 10, 1, "R6 grant plus cpl");
      cyc(0, 0, 1, 10, 0, "R6 to limit");
      cyc(0, 0, 1, 10, 0, "R6 blocked at limit");
      drain();

      // R1: each limit code filled by receive alone
      shared_lim = 0;
      for (int code = 0; code < 8; code++) begin
         max_out_code = 3'(code);
         for (int i = 0; i < f_lim(code) + 1; i++) cyc(0, 0, 1, 40, 0, "R1 limit sweep");
         drain();
      end

      // R8: lengths below, at and above each cap
      max_out_code = 7;
      for (int code = 0; code < 4; code++) begin
         rd_size_code = 2'(code);
         cyc(0, 0, 1, f_cap(code) - 1, 0, "R8 below cap");
         cyc(1, f_cap(code), 0, 0, 0, "R8 at cap");
         cyc(1, f_cap(code) + 1, 0, 0, 0, "R8 above cap");
         cyc(0, 0, 1, 8191, 0, "R8 max length");
         drain();
      end

      // Random mix over all rules (R1 R2 R3 R4 R5 R6 R8)
      void'($urandom(32'd2024));
      for (int n = 0; n < 4000; n++) begin
         if (n % 64 == 0) begin
            max_out_code = 3'($urandom_range(0, 7));
            shared_lim   = 5'($urandom_range(0, 31));
            rd_size_code = 2'($urandom_range(0, 3));
         end
         cyc(1'($urandom_range(0, 1)), int'($urandom_range(0, 8191)),
             1'($urandom_range(0, 1)), int'($urandom_range(0, 8191)),
             ($urandom_range(0, 9) < 4), "R4 random");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R4 watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule